// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This unit sits in a processor datapath and performs 32-bit arithmetic that clamps instead of wrapping. Each operation takes two operands, a 5-bit saturation position and a 4-bit operation code. The unit returns one result and, whenever it clamps, raises a shared saturation flag. The flag stays high across later operations until software logic pulses a dedicated clear input.

The available operations are:
- signed add and subtract;
- unsigned add and subtract;
- an add that wraps but still reports signed overflow;
- signed doubling;
- saturation of a value to a programmable bit position, in signed and unsigned forms;
- two-lane halfword versions of the positional saturation, each lane clamped on its own.

An input strobe launches an operation. The result, the updated flag and an output valid pulse appear one clock later.

Top module: `sat_arith_unit`

## Requirements
- R1: Signed add (op code 0) overflows when both operands share a sign and the sum's sign differs from it. On overflow the result is 0x7FFFFFFF if operand A is non-negative and 0x80000000 if it is negative, and the flag is set. Without overflow the result is the plain sum.
- R2: Signed subtract (op code 1) overflows when the operands differ in sign and the difference's sign differs from operand A. It clamps in the same way as R1 and sets the flag. Without overflow the result is A−B.
- R3: Unsigned add (op code 2) gives 0xFFFFFFFF and sets the flag when the wrapped sum is below A. Unsigned subtract (op code 3) gives 0 and sets the flag when the wrapped difference is above A. Otherwise each returns its plain result.
- R4: The wrap add (op code 4) always returns the modulo-2^32 sum. It sets the flag on signed overflow as defined in R1 but does not clamp.
- R5: Signed doubling (op code 5) of A behaves as follows:
  - A ≥ 0x40000000 (as signed) gives 0x7FFFFFFF;
  - A ≤ 0xC0000000 (as signed) gives 0x80000000;
  - both of those cases set the flag;
  - any other A gives A shifted left by one.
- R6: Signed positional saturation (op code 6) of A at position s works on t = A arithmetically shifted right by s:
  - t > 0 gives 2^s−1;
  - t < −1 gives the bitwise complement of 2^s−1;
  - both of those cases set the flag;
  - otherwise A passes through unchanged.
- R7: Unsigned positional saturation (op code 7) of A at position s gives 0 for negative A and 2^s−1 for A above 2^s−1. Both cases set the flag; otherwise A passes through.
- R8: The dual-halfword forms (op code 8 signed, op code 9 unsigned) sign-extend A[15:0] and A[31:16] separately. They saturate each lane with the same s as in R6/R7, place the low 16 bits of each lane result in the matching half of the result, and set the flag if either lane clamps.
- R9: The flag is 0 after reset. Once set, it stays set through any later non-clamping operation. A clear pulse with no strobe makes it 0 on the next cycle.
- R10: When a clear pulse and a clamping operation arrive in the same cycle, the flag ends up set. A clear pulse together with a non-clamping operation leaves it cleared.
- R11: Op codes 10 to 15 return operand A unchanged and leave the flag as it was.
- R12: The result and out_valid appear on the clock edge that samples in_valid. out_valid is high for exactly one cycle per strobe, and the result holds its value while no strobe arrives. The result is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that launches an operation |
| op | input | 4 | Operation code |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| sat_pos | input | 5 | Saturation bit position s |
| flag_clear | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The flag has two sources that can act in the same cycle: the clear input and a clamp from the operation being launched. The bench sets the flag, then raises flag_clear on the same clock as a strobe. It does this once with an operation that clamps and once with one that does not. On the following cycle it expects the flag to be 1 in the first case and 0 in the second. It also checks that a clear issued without any strobe always wins, and that an unused op code leaves a set flag untouched.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;

  localparam int DATA_W = 32;
  localparam int POS_W  = 5;
  localparam int LANE_W = 16;

  typedef enum logic [3:0] {
    OP_SADD   = 4'd0,
    OP_SSUB   = 4'd1,
    OP_UADD   = 4'd2,
    OP_USUB   = 4'd3,
    OP_WADD   = 4'd4,
    OP_SDBL   = 4'd5,
    OP_SSATP  = 4'd6,
    OP_USATP  = 4'd7,
    OP_SSAT2H = 4'd8,
    OP_USAT2H = 4'd9
  } sat_op_e;

  localparam logic [3:0] OP_LAST = 4'd9;

endpackage

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sadd_res,
  output logic         sadd_sat,
  output logic [W-1:0] ssub_res,
  output logic         ssub_sat,
  output logic [W-1:0] uadd_res,
  output logic         uadd_sat,
  output logic [W-1:0] usub_res,
  output logic         usub_sat,
  output logic [W-1:0] wadd_res,
  output logic         wadd_sat
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sum, diff, clamp;
  logic         ovf_add, ovf_sub;

  always_comb begin
    sum     = a + b;
    diff    = a - b;
    clamp   = a[W-1] ? NEG_MIN : POS_MAX;
    ovf_add = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    ovf_sub = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);

    sadd_res = ovf_add ? clamp : sum;
    sadd_sat = ovf_add;
    ssub_res = ovf_sub ? clamp : diff;
    ssub_sat = ovf_sub;

    uadd_sat = (sum < a);
    uadd_res = uadd_sat ? {W{1'b1}} : sum;
    usub_sat = (diff > a);
    usub_res = usub_sat ? {W{1'b0}} : diff;

    wadd_res = sum;
    wadd_sat = ovf_add;
  end
endmodule

// File: rtl/sat_double_unit.sv
module sat_double_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam logic [W-1:0] HI_EDGE = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] LO_EDGE = {2'b11, {(W-2){1'b0}}};
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic too_high, too_low;

  always_comb begin
    too_high = $signed(a) >= $signed(HI_EDGE);
    too_low  = $signed(a) <= $signed(LO_EDGE);
    if (too_high)     res = POS_MAX;
    else if (too_low) res = NEG_MIN;
    else              res = {a[W-2:0], 1'b0};
    sat = too_high || too_low;
  end
endmodule

// File: rtl/sat_pos_unit.sv
module sat_pos_unit #(
  parameter int W         = 32,
  parameter int POS_W     = 5,
  parameter bit IS_SIGNED = 1'b1
) (
  input  logic [W-1:0]     val,
  input  logic [POS_W-1:0] pos,
  output logic [W-1:0]     res,
  output logic             sat
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] limit;

  assign limit = (ONE << pos) - ONE;

  generate
    if (IS_SIGNED) begin : g_signed
      logic [W-1:0] top;
      logic         above, below;
      always_comb begin
        top   = $unsigned($signed(val) >>> pos);
        above = !top[W-1] && (top != '0);
        below = top[W-1] && (top != {W{1'b1}});
        if (above)      res = limit;
        else if (below) res = ~limit;
        else            res = val;
        sat = above || below;
      end
    end else begin : g_unsigned
      logic negative, above;
      always_comb begin
        negative = val[W-1];
        above    = !negative && (val > limit);
        if (negative)   res = '0;
        else if (above) res = limit;
        else            res = val;
        sat = negative || above;
      end
    end
  endgenerate
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sat_arith_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int PW  = POS_W,
  parameter int LW  = LANE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [PW-1:0] sat_pos,
  input  logic          flag_clear,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          sat_flag
);
  localparam int LANES = DW / LW;

  logic [DW-1:0] sadd_r, ssub_r, uadd_r, usub_r, wadd_r, dbl_r, ssp_r, usp_r;
  logic          sadd_s, ssub_s, uadd_s, usub_s, wadd_s, dbl_s, ssp_s, usp_s;
  logic [DW-1:0] ssh_r, ush_r;
  logic [LANES-1:0] ssh_s, ush_s;

  sat_addsub_unit #(.W(DW)) u_addsub (
    .a(opa), .b(opb),
    .sadd_res(sadd_r), .sadd_sat(sadd_s),
    .ssub_res(ssub_r), .ssub_sat(ssub_s),
    .uadd_res(uadd_r), .uadd_sat(uadd_s),
    .usub_res(usub_r), .usub_sat(usub_s),
    .wadd_res(wadd_r), .wadd_sat(wadd_s)
  );

  sat_double_unit #(.W(DW)) u_double (
    .a(opa), .res(dbl_r), .sat(dbl_s)
  );

  sat_pos_unit #(.W(DW), .POS_W(PW), .IS_SIGNED(1'b1)) u_ssat_full (
    .val(opa), .pos(sat_pos), .res(ssp_r), .sat(ssp_s)
  );

  sat_pos_unit #(.W(DW), .POS_W(PW), .IS_SIGNED(1'b0)) u_usat_full (
    .val(opa), .pos(sat_pos), .res(usp_r), .sat(usp_s)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [DW-1:0] lane_in, s_out, u_out;
      assign lane_in = {{(DW-LW){opa[g*LW+LW-1]}}, opa[g*LW +: LW]};

      sat_pos_unit #(.W(DW), .POS_W(PW), .IS_SIGNED(1'b1)) u_ssat_lane (
        .val(lane_in), .pos(sat_pos), .res(s_out), .sat(ssh_s[g])
      );
      sat_pos_unit #(.W(DW), .POS_W(PW), .IS_SIGNED(1'b0)) u_usat_lane (
        .val(lane_in), .pos(sat_pos), .res(u_out), .sat(ush_s[g])
      );

      assign ssh_r[g*LW +: LW] = s_out[LW-1:0];
      assign ush_r[g*LW +: LW] = u_out[LW-1:0];
    end
  endgenerate

  logic [DW-1:0] nxt_res;
  logic          nxt_sat;

  always_comb begin
    nxt_res = opa;
    nxt_sat = 1'b0;
    case (op)
      OP_SADD:   begin nxt_res = sadd_r; nxt_sat = sadd_s;  end
      OP_SSUB:   begin nxt_res = ssub_r; nxt_sat = ssub_s;  end
      OP_UADD:   begin nxt_res = uadd_r; nxt_sat = uadd_s;  end
      OP_USUB:   begin nxt_res = usub_r; nxt_sat = usub_s;  end
      OP_WADD:   begin nxt_res = wadd_r; nxt_sat = wadd_s;  end
      OP_SDBL:   begin nxt_res = dbl_r;  nxt_sat = dbl_s;   end
      OP_SSATP:  begin nxt_res = ssp_r;  nxt_sat = ssp_s;   end
      OP_USATP:  begin nxt_res = usp_r;  nxt_sat = usp_s;   end
      OP_SSAT2H: begin nxt_res = ssh_r;  nxt_sat = |ssh_s;  end
      OP_USAT2H: begin nxt_res = ush_r;  nxt_sat = |ush_s;  end
      default:   begin nxt_res = opa;    nxt_sat = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt_res;
      sat_flag <= (sat_flag && !flag_clear) || (in_valid && nxt_sat);
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R12
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R12
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R12
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    sat_flag && !flag_clear |=> sat_flag); // R9
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
    flag_clear && !in_valid |=> !sat_flag); // R9
  AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op > OP_LAST) |=> result == $past(opa)); // R11
  AST_UNUSED_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op > OP_LAST) && !flag_clear |=> $stable(sat_flag)); // R11
endmodule

// File: tb/sat_arith_unit_bench.sv
module sat_arith_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, flag_clear;
  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic [4:0]  sat_pos;
  logic        out_valid, sat_flag;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sat_arith_unit u_sat_arith_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .opa(opa),
    .opb(opb), .sat_pos(sat_pos), .flag_clear(flag_clear),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge; outputs are sampled at the next falling edge.
  task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] s, input logic clr);
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b; sat_pos = s; flag_clear = clr;
    @(negedge clk);
    in_valid = 1'b0; flag_clear = 1'b0;
  endtask

  task automatic clear_only();
    @(negedge clk);
    flag_clear = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 reset result", result, 32'h0);
    chk("R12 reset valid", {31'b0, out_valid}, 32'h0);
    chk("R9 reset flag", {31'b0, sat_flag}, 32'h0);
  endtask

  task automatic t_sadd();
    run(4'd0, 32'd5, 32'd7, 5'd0, 1'b1);
    chk("R1 plain sum", result, 32'd12);
    chk("R1 plain flag", {31'b0, sat_flag}, 32'h0);
    run(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b0);
    chk("R1 pos clamp", result, 32'h7FFFFFFF);
    chk("R1 pos flag", {31'b0, sat_flag}, 32'h1);
    run(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1'b1);
    chk("R1 neg clamp", result, 32'h80000000);
    chk("R1 neg flag", {31'b0, sat_flag}, 32'h1);
  endtask

  task automatic t_ssub();
    run(4'd1, 32'd10, 32'd3, 5'd0, 1'b1);
    chk("R2 plain diff", result, 32'd7);
    chk("R2 plain flag", {31'b0, sat_flag}, 32'h0);
    run(4'd1, 32'h80000000, 32'h1, 5'd0, 1'b0);
    chk("R2 neg clamp", result, 32'h80000000);
    chk("R2 neg flag", {31'b0, sat_flag}, 32'h1);
    run(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b1);
    chk("R2 pos clamp", result, 32'h7FFFFFFF);
  endtask

  task automatic t_unsigned();
    run(4'd2, 32'd1, 32'd2, 5'd0, 1'b1);
    chk("R3 uadd plain", result, 32'd3);
    chk("R3 uadd plain flag", {31'b0, sat_flag}, 32'h0);
    run(4'd2, 32'hFFFFFFF0, 32'h20, 5'd0, 1'b0);
    chk("R3 uadd clamp", result, 32'hFFFFFFFF);
    chk("R3 uadd flag", {31'b0, sat_flag}, 32'h1);
    run(4'd3, 32'd5, 32'd3, 5'd0, 1'b1);
    chk("R3 usub plain", result, 32'd2);
    chk("R3 usub plain flag", {31'b0, sat_flag}, 32'h0);
    run(4'd3, 32'd3, 32'd5, 5'd0, 1'b0);
    chk("R3 usub clamp", result, 32'h0);
    chk("R3 usub flag", {31'b0, sat_flag}, 32'h1);
  endtask

  task automatic t_wadd();
    run(4'd4, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b1);
    chk("R4 wrap result", result, 32'h80000000);
    chk("R4 wrap flag", {31'b0, sat_flag}, 32'h1);
    run(4'd4, 32'd100, 32'd23, 5'd0, 1'b1);
    chk("R4 no overflow", result, 32'd123);
    chk("R4 no overflow flag", {31'b0, sat_flag}, 32'h0);
  endtask

  task automatic t_double();
    run(4'd5, 32'h40000000, 32'h0, 5'd0, 1'b1);
    chk("R5 high edge", result, 32'h7FFFFFFF);
    chk("R5 high flag", {31'b0, sat_flag}, 32'h1);
    run(4'd5, 32'hC0000000, 32'h0, 5'd0, 1'b1);
    chk("R5 low edge", result, 32'h80000000);
    chk("R5 low flag", {31'b0, sat_flag}, 32'h1);
    run(4'd5, 32'h3FFFFFFF, 32'h0, 5'd0, 1'b1);
    chk("R5 below high", result, 32'h7FFFFFFE);
    chk("R5 below high flag", {31'b0, sat_flag}, 32'h0);
    run(4'd5, 32'hC0000001, 32'h0, 5'd0, 1'b0);
    chk("R5 above low", result, 32'h80000002);
    chk("R5 above low flag", {31'b0, sat_flag}, 32'h0);
  endtask

  task automatic t_ssatp();
    run(4'd6, 32'd127, 32'h0, 5'd7, 1'b1);
    chk("R6 pass top", result, 32'd127);
    chk("R6 pass flag", {31'b0, sat_flag}, 32'h0);
    run(4'd6, 32'hFFFFFF80, 32'h0, 5'd7, 1'b0);
    chk("R6 pass bottom", result, 32'hFFFFFF80);
    chk("R6 pass bottom flag", {31'b0, sat_flag}, 32'h0);
    run(4'd6, 32'd200, 32'h0, 5'd7, 1'b0);
    chk("R6 clamp high", result, 32'h0000007F);
    chk("R6 clamp high flag", {31'b0, sat_flag}, 32'h1);
    run(4'd6, 32'hFFFFFF38, 32'h0, 5'd7, 1'b1);
    chk("R6 clamp low", result, 32'hFFFFFF80);
    chk("R6 clamp low flag", {31'b0, sat_flag}, 32'h1);
  endtask

  task automatic t_usatp();
    run(4'd7, 32'd255, 32'h0, 5'd8, 1'b1);
    chk("R7 pass", result, 32'd255);
    chk("R7 pass flag", {31'b0, sat_flag}, 32'h0);
    run(4'd7, 32'hFFFFFFFB, 32'h0, 5'd8, 1'b0);
    chk("R7 negative", result, 32'h0);
    chk("R7 negative flag", {31'b0, sat_flag}, 32'h1);
    run(4'd7, 32'd300, 32'h0, 5'd8, 1'b1);
    chk("R7 above", result, 32'd255);
    chk("R7 above flag", {31'b0, sat_flag}, 32'h1);
  endtask

  task automatic t_dual();
    run(4'd8, 32'h0005FFF0, 32'h0, 5'd7, 1'b1);
    chk("R8 signed pass", result, 32'h0005FFF0);
    chk("R8 signed pass flag", {31'b0, sat_flag}, 32'h0);
    run(4'd8, 32'h00C8FF38, 32'h0, 5'd7, 1'b0);
    chk("R8 signed both lanes", result, 32'h007FFF80);
    chk("R8 signed flag", {31'b0, sat_flag}, 32'h1);
    run(4'd9, 32'hFFFB0064, 32'h0, 5'd8, 1'b1);
    chk("R8 unsigned lanes", result, 32'h00000064);
    chk("R8 unsigned flag", {31'b0, sat_flag}, 32'h1);
  endtask

  task automatic t_sticky();
    run(4'd2, 32'hFFFFFFFF, 32'h1, 5'd0, 1'b1);
    run(4'd0, 32'd1, 32'd1, 5'd0, 1'b0);
    chk("R9 later result", result, 32'd2);
    chk("R9 flag kept", {31'b0, sat_flag}, 32'h1);
    clear_only();
    chk("R9 cleared", {31'b0, sat_flag}, 32'h0);
    chk("R9 result unchanged by clear", result, 32'd2);
  endtask

  task automatic t_collision();
    run(4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b0);
    run(4'd3, 32'd0, 32'd1, 5'd0, 1'b1);
    chk("R10 clamp wins", {31'b0, sat_flag}, 32'h1);
    run(4'd0, 32'd1, 32'd1, 5'd0, 1'b1);
    chk("R10 clear wins", {31'b0, sat_flag}, 32'h0);
  endtask

  task automatic t_unused();
    run(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b1);
    run(4'hF, 32'h12345678, 32'hFFFFFFFF, 5'd3, 1'b0);
    chk("R11 pass A", result, 32'h12345678);
    chk("R11 flag held set", {31'b0, sat_flag}, 32'h1);
    clear_only();
    run(4'd10, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0);
    chk("R11 code 10 pass", result, 32'hFFFFFFFF);
    chk("R11 flag held clear", {31'b0, sat_flag}, 32'h0);
  endtask

  task automatic t_timing();
    @(negedge clk);
    in_valid = 1'b1; op = 4'd0; opa = 32'd40; opb = 32'd2; flag_clear = 1'b0;
    chk("R12 valid low before edge", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    in_valid = 1'b0; opa = 32'd999;
    chk("R12 valid after edge", {31'b0, out_valid}, 32'h1);
    chk("R12 result after edge", result, 32'd42);
    @(negedge clk);
    chk("R12 single pulse", {31'b0, out_valid}, 32'h0);
    chk("R12 result held", result, 32'd42);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; flag_clear = 1'b0;
    op = '0; opa = '0; opb = '0; sat_pos = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_sadd();
    t_ssub();
    t_unsigned();
    t_wadd();
    t_double();
    t_ssatp();
    t_usatp();
    t_dual();
    t_sticky();
    t_collision();
    t_unused();
    t_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule